// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobes of an 8-bit controller's external memory bus, on which the low address byte and the data share one set of pins. Each machine cycle is divided into twelve oscillator periods, marked by a clock enable. Each half of a machine cycle is one instruction-fetch slot. In each slot the block pulses the address latch strobe. If the program counter points outside on-chip program memory, it also puts the low address byte on the shared bus and then asserts the program-store strobe so that an external memory can return the code byte.

The core can ask for one external data read or write in place of the next machine cycle. The address is either a 16-bit pointer or an 8-bit register value. In the 8-bit case the current port-2 latch provides the high address byte. For the whole data machine cycle, the second address latch pulse and both program-store strobes are dropped. A single read or write strobe, six oscillator periods long, takes their place. Read data is captured as the read strobe ends.

The level on the external-access pin is captured while reset is asserted. After reset only that captured value, and not the live pin, decides whether a fetch goes to internal or external memory.

Top module: `xbus_cycle_seq`

## Requirements
- R1: A machine cycle is 12 clocks on which `osc_en` is high, numbered phase 0 to 11. In a machine cycle with no data access, `ale` is high in phases 0-1 and 6-7 and low in all other phases.
- R2: In a fetch half (phases 0-5 or 6-11) that goes to external memory, `bus_out` carries `pc[7:0]` with `bus_oe` high in half-phases 0-2. `psen_n` is low in half-phases 3-5. `addr_hi` carries `pc[15:8]` for the whole half. `pc` is sampled as the half starts.
- R3: In a fetch half served internally, `psen_n` stays high, `bus_oe` stays low and `addr_hi` follows `p2_latch`.
- R4: `ea_pin` is sampled only while `rst` is high. When the sampled level is 0, every fetch goes external. A change on the pin after reset has no effect until the next reset.
- R5: When the sampled level is 1, a fetch goes external only when `pc` is greater than the `INT_TOP` parameter (default 16'h1FFF). 16'h1FFF is therefore internal and 16'h2000 is external.
- R6: In a data machine cycle, `ale` is high only in phases 0-1. `psen_n` stays high in all 12 phases. The low address byte is driven on `bus_out` with `bus_oe` high in phases 0-2.
- R7: For a data read, `rd_n` is low in phases 4-9 and `bus_oe` is low in phases 3-11. `bus_in` is captured into `rdata` on the enabled edge that ends phase 9. `rdata_valid` is high for exactly one clock, during phase 10.
- R8: For a data write, `bus_out` carries `wdata` with `bus_oe` high in phases 3-9, and `wr_n` is low in phases 4-9. `wr_n` and `rd_n` are never low together.
- R9: When `dreq_wide`=1, the data address is `dptr` (high byte on `addr_hi`, low byte on `bus_out`). When `dreq_wide`=0, the data address is `{p2_latch, ri_addr}`. `addr_hi` holds that high byte for all 12 phases.
- R10: `dreq` is sampled only on the enabled edge that ends phase 11. When it is taken, `dack` is high for one clock, during phase 0, and that machine cycle is a data cycle (`dreq_write`=1 write, 0 read). Otherwise the cycle is a fetch cycle and `dack` stays low.
- R11: While `osc_en` is low the phase does not advance, all strobe and bus outputs hold their values, and no request is taken.
- R12: While `rst` is high, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, and `bus_oe`, `dack` and `rdata_valid` are 0. The first enabled edge after reset starts phase 0 of a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also samples `ea_pin` |
| osc_en | input | 1 | One-clock enable per oscillator period |
| ea_pin | input | 1 | External-access pin level (0 = all fetches external) |
| pc | input | 16 | Program counter of the current fetch |
| p2_latch | input | 8 | Port-2 output latch contents |
| dreq | input | 1 | Request for an external data access, held until `dack` |
| dreq_write | input | 1 | 1 = write, 0 = read |
| dreq_wide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register address |
| dptr | input | 16 | 16-bit data pointer |
| ri_addr | input | 8 | 8-bit register-indirect address |
| wdata | input | 8 | Write data byte |
| dack | output | 1 | One-clock acknowledge in phase 0 of the data cycle |
| bus_in | input | 8 | Shared bus value read from the pads |
| bus_out | output | 8 | Shared bus value driven to the pads |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Last byte read from external data memory |
| rdata_valid | output | 1 | One-clock pulse when `rdata` is updated |

## Verification
The assertions assume that reset lasts at least one clock with `osc_en` high. This lets the phase counter start from a known last phase, so the first address latch pulse lasts two full samples. They also assume that `dreq` and its address fields stay stable from the moment they are raised until `dack` is seen. The stimulus holds reset for three enabled clocks. It sets request fields only at the negative edge of the last phase or during a stall, and it drops `dreq` at the negative edge of the phase-0 sample that shows `dack`. `osc_en` is held low only across a whole-phase stall, so the phase count the bench keeps stays in step with the design.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned PH_N   = 12;
    localparam int unsigned HALF_N = PH_N / 2;
    localparam int unsigned PH_W   = $clog2(PH_N);

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam phase_t PH_LAST      = phase_t'(PH_N - 1);
    localparam phase_t PH_HALF      = phase_t'(HALF_N);
    localparam phase_t PH_HALF_LAST = phase_t'(HALF_N - 1);

    // positions inside a half (fetch slot)
    localparam phase_t ALE_LEN    = phase_t'(2);
    localparam phase_t ADDR_LAST  = phase_t'(2);
    localparam phase_t PSEN_FIRST = phase_t'(3);

    // positions inside a data machine cycle
    localparam phase_t WDAT_FIRST = phase_t'(3);
    localparam phase_t STB_FIRST  = phase_t'(4);
    localparam phase_t STB_LAST   = phase_t'(9);

    typedef enum logic [1:0] {
        CK_FETCH = 2'd0,
        CK_READ  = 2'd1,
        CK_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } bus_addr_t;

    typedef struct packed {
        logic  ale;
        logic  psen_n;
        logic  rd_n;
        logic  wr_n;
        logic  oe;
        byte_t dout;
    } strobes_t;

    function automatic phase_t half_pos(input phase_t ph);
        return (ph >= PH_HALF) ? phase_t'(ph - PH_HALF) : ph;
    endfunction

    function automatic logic in_span(input phase_t p, input phase_t a, input phase_t b);
        return (p >= a) && (p <= b);
    endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
    import xbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   osc_en,
    output phase_t ph_o,
    output logic   half_wrap_o,
    output logic   mc_wrap_o
);

    phase_t ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_LAST;
        end else if (osc_en) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : phase_t'(ph_q + 1'b1);
        end
    end

    assign ph_o        = ph_q;
    assign mc_wrap_o   = osc_en && (ph_q == PH_LAST);
    assign half_wrap_o = osc_en && ((ph_q == PH_HALF_LAST) || (ph_q == PH_LAST));

    // R11: a clock without enable leaves the phase untouched
    assert_phase_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (!osc_en) |=> $stable(ph_q));

    // R1: the phase never leaves 0..11
    assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
        ph_q <= PH_LAST);

endmodule

// File: rtl/xbus_fetch_route.sv
module xbus_fetch_route
    import xbus_pkg::*;
#(
    parameter word_t INT_TOP = 16'h1FFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ea_pin,
    input  word_t pc,
    output logic  ext_o
);

    logic ea_q;

    // pin level is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q <= ea_pin;
        end
    end

    assign ext_o = !ea_q || (pc > INT_TOP);

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_pkg::*;
(
    input  phase_t    ph,
    input  cyc_kind_e kind,
    input  logic      ext,
    input  byte_t     addr_lo,
    input  byte_t     wdata,
    output strobes_t  stb_o
);

    phase_t hp;
    logic   second;
    logic   fetch;
    logic   data_stb;
    logic   addr_ph;
    logic   wr_drive;

    always_comb begin
        hp       = half_pos(ph);
        second   = (ph >= PH_HALF);
        fetch    = (kind == CK_FETCH);
        data_stb = !fetch && in_span(ph, STB_FIRST, STB_LAST);
        addr_ph  = (hp <= ADDR_LAST) && !(!fetch && second);
        wr_drive = (kind == CK_WRITE) && in_span(ph, WDAT_FIRST, STB_LAST);

        stb_o.ale    = (hp < ALE_LEN) && !(!fetch && second);
        stb_o.psen_n = !(fetch && ext && (hp >= PSEN_FIRST));
        stb_o.rd_n   = !(data_stb && (kind == CK_READ));
        stb_o.wr_n   = !(data_stb && (kind == CK_WRITE));
        stb_o.oe     = (addr_ph && (!fetch || ext)) || wr_drive;

        if (addr_ph) begin
            stb_o.dout = addr_lo;
        end else if (kind == CK_WRITE) begin
            stb_o.dout = wdata;
        end else begin
            stb_o.dout = '0;
        end
    end

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter word_t INT_TOP = 16'h1FFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_en,
    input  logic        ea_pin,
    input  logic [15:0] pc,
    input  logic [7:0]  p2_latch,
    input  logic        dreq,
    input  logic        dreq_write,
    input  logic        dreq_wide,
    input  logic [15:0] dptr,
    input  logic [7:0]  ri_addr,
    input  logic [7:0]  wdata,
    output logic        dack,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    output logic [7:0]  addr_hi,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  rdata,
    output logic        rdata_valid
);

    phase_t    ph;
    logic      half_wrap;
    logic      mc_wrap;
    logic      fetch_ext;
    cyc_kind_e kind_q;
    logic      ext_q;
    bus_addr_t addr_q;
    byte_t     wdat_q;
    logic      dack_q;
    byte_t     rdata_q;
    logic      rvalid_q;
    strobes_t  stb;

    xbus_phase_ctr u_phase (
        .clk         (clk),
        .rst         (rst),
        .osc_en      (osc_en),
        .ph_o        (ph),
        .half_wrap_o (half_wrap),
        .mc_wrap_o   (mc_wrap)
    );

    xbus_fetch_route #(.INT_TOP(INT_TOP)) u_route (
        .clk    (clk),
        .rst    (rst),
        .ea_pin (ea_pin),
        .pc     (pc),
        .ext_o  (fetch_ext)
    );

    // cycle kind and address are fixed at each slot start
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= CK_FETCH;
            ext_q    <= 1'b0;
            addr_q   <= '0;
            wdat_q   <= '0;
            dack_q   <= 1'b0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            dack_q   <= 1'b0;
            rvalid_q <= 1'b0;
            if (mc_wrap) begin
                if (dreq) begin
                    kind_q <= dreq_write ? CK_WRITE : CK_READ;
                    addr_q <= dreq_wide ? bus_addr_t'(dptr)
                                        : bus_addr_t'({p2_latch, ri_addr});
                    wdat_q <= wdata;
                    ext_q  <= 1'b0;
                    dack_q <= 1'b1;
                end else begin
                    kind_q <= CK_FETCH;
                    addr_q <= bus_addr_t'(pc);
                    ext_q  <= fetch_ext;
                end
            end else if (half_wrap && (kind_q == CK_FETCH)) begin
                addr_q <= bus_addr_t'(pc);
                ext_q  <= fetch_ext;
            end
            if (osc_en && (kind_q == CK_READ) && (ph == STB_LAST)) begin
                rdata_q  <= bus_in;
                rvalid_q <= 1'b1;
            end
        end
    end

    xbus_strobe_dec u_dec (
        .ph      (ph),
        .kind    (kind_q),
        .ext     (ext_q),
        .addr_lo (addr_q.lo),
        .wdata   (wdat_q),
        .stb_o   (stb)
    );

    assign ale         = stb.ale;
    assign psen_n      = stb.psen_n;
    assign rd_n        = stb.rd_n;
    assign wr_n        = stb.wr_n;
    assign bus_oe      = stb.oe;
    assign bus_out     = stb.dout;
    assign addr_hi     = ((kind_q != CK_FETCH) || ext_q) ? addr_q.hi : p2_latch;
    assign dack        = dack_q;
    assign rdata       = rdata_q;
    assign rdata_valid = rvalid_q;

    // R1: no strobe overlaps an address latch pulse
    assert_ale_idle_R1: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n));

    // R1: every address latch pulse spans at least two samples
    assert_ale_width_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> $past(ale, 2));

    // R6: program-store and data strobes never overlap
    assert_fetch_vs_data_R6: assert property (@(posedge clk) disable iff (rst)
        (!psen_n) |-> (rd_n && wr_n));

    // R8: read and write strobes are exclusive
    assert_rdwr_excl_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_n) |-> wr_n);

    // R8: write data is on the bus before the write strobe falls
    assert_wdata_first_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $past(bus_oe));

    // R7: captured read byte is flagged as the read strobe ends
    assert_rvalid_end_R7: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $rose(rd_n));

    // R10: acknowledge coincides with the first latch pulse of the cycle
    assert_ack_phase0_R10: assert property (@(posedge clk) disable iff (rst)
        dack |-> ale);

endmodule

// File: tb/test_xbus_cycle_seq.sv
module test_xbus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b1;
    logic        ea_pin = 1'b1;
    logic [15:0] pc = '0;
    logic [7:0]  p2_latch = '0;
    logic        dreq = 1'b0;
    logic        dreq_write = 1'b0;
    logic        dreq_wide = 1'b0;
    logic [15:0] dptr = '0;
    logic [7:0]  ri_addr = '0;
    logic [7:0]  wdata = '0;
    logic        dack;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  addr_hi;
    logic        ale;
    logic        psen_n;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  rdata;
    logic        rdata_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xbus_cycle_seq i_xbus_cycle_seq (
        .clk(clk), .rst(rst), .osc_en(osc_en), .ea_pin(ea_pin), .pc(pc),
        .p2_latch(p2_latch), .dreq(dreq), .dreq_write(dreq_write),
        .dreq_wide(dreq_wide), .dptr(dptr), .ri_addr(ri_addr), .wdata(wdata),
        .dack(dack), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R12: reset state, pin sampled during reset
    task automatic do_reset(input bit ea);
        @(negedge clk);
        rst = 1'b1; ea_pin = ea; osc_en = 1'b1; dreq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12", "ale", {15'd0, ale}, 16'd0);
        chk("R12", "psen_n", {15'd0, psen_n}, 16'd1);
        chk("R12", "rd_n", {15'd0, rd_n}, 16'd1);
        chk("R12", "wr_n", {15'd0, wr_n}, 16'd1);
        chk("R12", "bus_oe", {15'd0, bus_oe}, 16'd0);
        chk("R12", "dack", {15'd0, dack}, 16'd0);
        chk("R12", "rdata_valid", {15'd0, rdata_valid}, 16'd0);
        rst = 1'b0;
    endtask

    // one machine cycle, sampled at each of its 12 negative edges
    task automatic run_mc(input string ext_req, input bit data, input bit wr,
                          input bit ext, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rv);
        for (int k = 0; k < 12; k++) begin
            int  hp;
            bit  second, addr_ph, e_ale, e_psen_n, e_rd_n, e_wr_n, e_oe;
            logic [7:0] e_out, e_hi;
            string r_ale, r_psen, r_oe, r_hi;
            @(negedge clk);
            hp       = k % 6;
            second   = (k >= 6);
            addr_ph  = (hp <= 2) && !(data && second);
            e_ale    = (hp < 2) && !(data && second);
            e_psen_n = !(!data && ext && hp >= 3);
            e_rd_n   = !(data && !wr && k >= 4 && k <= 9);
            e_wr_n   = !(data && wr && k >= 4 && k <= 9);
            e_oe     = (addr_ph && (data || ext)) || (data && wr && k >= 3 && k <= 9);
            e_out    = addr_ph ? a[7:0] : wd;
            e_hi     = (data || ext) ? a[15:8] : p2_latch;
            r_ale    = data ? "R6" : "R1";
            r_psen   = data ? "R6" : ext_req;
            r_oe     = data ? (wr ? "R8" : "R7") : ext_req;
            r_hi     = data ? "R9" : ext_req;
            chk(r_ale, $sformatf("ale ph%0d", k), {15'd0, ale}, {15'd0, e_ale});
            chk(r_psen, $sformatf("psen_n ph%0d", k), {15'd0, psen_n}, {15'd0, e_psen_n});
            chk("R7", $sformatf("rd_n ph%0d", k), {15'd0, rd_n}, {15'd0, e_rd_n});
            chk("R8", $sformatf("wr_n ph%0d", k), {15'd0, wr_n}, {15'd0, e_wr_n});
            chk(r_oe, $sformatf("bus_oe ph%0d", k), {15'd0, bus_oe}, {15'd0, e_oe});
            if (e_oe)
                chk(data ? "R9" : "R2", $sformatf("bus_out ph%0d", k),
                    {8'd0, bus_out}, {8'd0, e_out});
            chk(r_hi, $sformatf("addr_hi ph%0d", k), {8'd0, addr_hi}, {8'd0, e_hi});
            if (k == 0) begin
                chk("R10", "dack ph0", {15'd0, dack}, {15'd0, data});
                dreq = 1'b0;
            end
            if (k == 1) chk("R10", "dack ph1", {15'd0, dack}, 16'd0);
            if (k == 10) begin
                chk("R7", "rdata_valid ph10", {15'd0, rdata_valid}, {15'd0, data && !wr});
                if (data && !wr) chk("R7", "rdata", {8'd0, rdata}, {8'd0, rv});
            end
            if (k == 11) chk("R7", "rdata_valid ph11", {15'd0, rdata_valid}, 16'd0);
        end
    endtask

    task automatic t_fetch(input string req, input logic [15:0] p, input bit ext);
        pc = p;
        run_mc(req, 1'b0, 1'b0, ext, p, 8'h00, 8'h00);
    endtask

    // R11: stall at the last phase, request pending but not taken
    task automatic t_stall(input int n);
        bit h_ale, h_psen, h_oe;
        h_ale = ale; h_psen = psen_n; h_oe = bus_oe;
        osc_en = 1'b0;
        dreq = 1'b1; dreq_write = 1'b0; dreq_wide = 1'b1;
        dptr = 16'hA55A; bus_in = 8'h3C;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R11", "ale held", {15'd0, ale}, {15'd0, h_ale});
            chk("R11", "psen_n held", {15'd0, psen_n}, {15'd0, h_psen});
            chk("R11", "bus_oe held", {15'd0, bus_oe}, {15'd0, h_oe});
            chk("R11", "no dack", {15'd0, dack}, 16'd0);
        end
        osc_en = 1'b1;
    endtask

    task automatic t_read_wide;
        run_mc("R7", 1'b1, 1'b0, 1'b0, 16'hA55A, 8'h00, 8'h3C);
    endtask

    task automatic t_read_narrow;
        dreq = 1'b1; dreq_write = 1'b0; dreq_wide = 1'b0;
        ri_addr = 8'h47; p2_latch = 8'h9E; dptr = 16'hFFFF; bus_in = 8'h81;
        run_mc("R9", 1'b1, 1'b0, 1'b0, 16'h9E47, 8'h00, 8'h81);
    endtask

    task automatic t_write_wide;
        dreq = 1'b1; dreq_write = 1'b1; dreq_wide = 1'b1;
        dptr = 16'h1234; wdata = 8'hC3; bus_in = 8'h00;
        run_mc("R8", 1'b1, 1'b1, 1'b0, 16'h1234, 8'hC3, 8'h00);
    endtask

    initial begin
        p2_latch = 8'h5A;
        do_reset(1'b1);
        t_fetch("R3", 16'h0123, 1'b0);
        t_fetch("R2", 16'h2345, 1'b1);
        t_stall(5);
        t_read_wide();
        t_read_narrow();
        t_write_wide();
        t_fetch("R10", 16'h2345, 1'b1);
        t_fetch("R5", 16'h1FFF, 1'b0);
        t_fetch("R5", 16'h2000, 1'b1);
        do_reset(1'b0);
        t_fetch("R4", 16'h0100, 1'b1);
        ea_pin = 1'b1;
        t_fetch("R4", 16'h0100, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule